// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive half of a bus-mastering Ethernet controller. Frames arrive as a byte stream with a valid/ready handshake and a last-byte marker. Each frame is stored in memory that host software has prepared. That memory holds a ring of descriptors, and each descriptor is four consecutive 32-bit words reached through one word-addressed memory port. When a frame begins, the engine reads the four words of the current descriptor.

If the device owns the descriptor, the engine stores the frame in the first buffer and packs the bytes little-endian into 32-bit words. It then writes back the status word with the stored length and the ownership bit cleared, raises a receive-done flag, and steps to the next descriptor. If the host still owns the descriptor, the frame is drained and discarded. A saturating missed-frame count then increments and a no-descriptor flag is raised.

Word 0 of a descriptor is status and word 1 is control. Word 2 is the first-buffer address and word 3 is the second-buffer address or chain pointer. All buffer and descriptor addresses are word addresses in the memory port's space, taken from the low address bits of the word.

Top module: `rx_desc_ring_engine`

## Requirements
- R1: After synchronous reset, rx_ready, mem_req, both status flags and the missed-frame count are 0.
- R2: While cfg_rx_en is 0, the engine accepts no stream bytes and makes no memory access.
- R3: When a frame starts, the engine makes exactly four reads at the current descriptor address plus 0, 1, 2 and 3. It accepts no stream byte while those reads are outstanding.
- R4: For an owned descriptor (status bit 31 = 1), byte k of the frame goes to byte lane k mod 4 (bits 8*(k mod 4)+7 : 8*(k mod 4)) of the word at buffer-1 address + k/4. In a final partial word, the lanes with no byte are 0.
- R5: At the end of the frame, the engine writes the status word with bit 31 = 0 and bits 26:16 = stored byte count. It makes this write only after all of the frame's data writes.
- R6: The buffer size is control bits 10:0. The engine writes no byte past that size. The stored count is then the size, and status bit 1 is set, but only if the frame was longer than the size.
- R7: If a frame arrives while the descriptor's status bit 31 = 0, the frame is consumed, nothing is written, the missed-frame count increments (saturating at all-ones), and sts_no_desc is set. The same descriptor is fetched again for the next frame.
- R8: After a completed frame, the next descriptor is chosen in this order. If control bit 25 (end of ring) is set, it is the list base. Otherwise, if control bit 24 (chained) is set, it is the word-3 address. Otherwise it is the current address + 4. End of ring takes precedence over chaining.
- R9: sts_rx_done is set when a status write-back is issued. Each flag is cleared by a 1 on its sts_clr bit (bit 0 for done, bit 1 for no-descriptor), and a set in the same cycle wins.
- R10: The list base is taken from cfg_list_base on each rising edge of cfg_rx_en, and the current descriptor returns to it.
- R11: The status write-back is the last memory write of each frame, and no read of the next descriptor is issued before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_list_base | input | AW | Ring base word address, taken on the rising edge of the enable |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Last byte of frame |
| rx_ready | output | 1 | Engine accepts the stream byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, one cycle after the read request is seen |
| sts_clr | input | 2 | Write-one-to-clear for the flags |
| sts_rx_done | output | 1 | Frame completed flag |
| sts_no_desc | output | 1 | Frame dropped, no descriptor flag |
| miss_count | output | MISS_W | Saturating missed-frame count |

## Verification
Frame lengths of one byte, lengths that are not a multiple of four, lengths that fit a buffer exactly and lengths that overrun it separate lane packing, partial-word zero fill and truncation flagging. A ring with one plain, one chained and one end-of-ring descriptor (also marked chained) shows which advance rule wins. The rule is visible because each frame lands at a distinct address. Host-owned descriptors, repeated drops and a base change while disabled cover frame dropping, count saturation and base reload. Random lengths and buffer sizes from a fixed seed mix these cases together.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 4;
  localparam int OWN_BIT    = 31;
  localparam int LEN_LSB    = 16;
  localparam int LEN_W      = 11;
  localparam int TRUNC_BIT  = 1;
  localparam int EOR_BIT    = 25;
  localparam int CHAIN_BIT  = 24;
  localparam int CNT_W      = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_WAITD, ST_DECIDE, ST_RECV, ST_DROP, ST_WB
  } rxr_state_e;

  function automatic logic [WORD_W-1:0] make_status(input logic [LEN_W-1:0] len,
                                                    input logic trunc);
    logic [WORD_W-1:0] w;
    w = '0;
    w[LEN_LSB +: LEN_W] = len;
    w[TRUNC_BIT] = trunc;
    w[OWN_BIT] = 1'b0;
    return w;
  endfunction
endpackage

// File: rtl/rxr_byte_packer.sv
module rxr_byte_packer #(
  parameter int WORD_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 store,
  input  logic                 flush,
  input  logic [$clog2(WORD_W/8)-1:0] lane,
  input  logic [7:0]           din,
  output logic [WORD_W-1:0]    word_out
);
  localparam int LANES = WORD_W / 8;

  logic [7:0] lane_q [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        lane_q[i] <= '0;
      end else if (store) begin
        if (flush)                lane_q[i] <= '0;
        else if (lane == i[$clog2(LANES)-1:0]) lane_q[i] <= din;
      end
    end
    assign word_out[8*i +: 8] = (lane == i[$clog2(LANES)-1:0]) ? din : lane_q[i];
  end
endmodule

// File: rtl/rxr_next_ptr.sv
module rxr_next_ptr #(
  parameter int AW = 10
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] link,
  input  logic          eor,
  input  logic          chain,
  output logic [AW-1:0] next
);
  localparam logic [AW-1:0] STRIDE = AW'(rxr_pkg::DESC_WORDS);

  always_comb begin
    if (eor)        next = base;
    else if (chain) next = link;
    else            next = cur + STRIDE;
  end
endmodule

// File: rtl/rxr_sat_counter.sv
module rxr_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)                     count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end

  // R7
  miss_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && count != TOP) |=> (count == $past(count) + 1'b1));

  // R7
  miss_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (count == TOP) |=> (count == TOP));
endmodule

// File: rtl/rx_desc_ring_engine.sv
module rx_desc_ring_engine
  import rxr_pkg::*;
#(
  parameter int AW     = 10,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_rx_en,
  input  logic [AW-1:0]     cfg_list_base,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  output logic              rx_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic [1:0]        sts_clr,
  output logic              sts_rx_done,
  output logic              sts_no_desc,
  output logic [MISS_W-1:0] miss_count
);
  localparam int LANE_W = $clog2(WORD_W/8);

  rxr_state_e st;
  logic [AW-1:0]     cur_desc, base_q, next_desc;
  logic              en_q;
  logic [1:0]        fidx;
  logic              tag1_v, tag2_v;
  logic [1:0]        tag1_i, tag2_i;
  logic              d_own, d_eor, d_chain;
  logic [LEN_W-1:0]  d_size;
  logic [AW-1:0]     d_buf1, d_link;
  logic [CNT_W-1:0]  byte_cnt;
  logic              trunc_q;
  logic              fits, flush, store, drop_end, set_done;
  logic [WORD_W-1:0] packed_word;
  logic [LEN_W-1:0]  stored_len;

  assign rx_ready = (st == ST_RECV) || (st == ST_DROP);
  assign fits     = byte_cnt < CNT_W'(d_size);
  assign store    = (st == ST_RECV) && rx_valid && fits;
  assign flush    = (byte_cnt[LANE_W-1:0] == '1) || rx_last ||
                    ((byte_cnt + 1'b1) == CNT_W'(d_size));
  assign drop_end = (st == ST_DROP) && rx_valid && rx_last;
  assign set_done = (st == ST_WB);
  assign stored_len = (byte_cnt > CNT_W'(d_size)) ? d_size : byte_cnt[LEN_W-1:0];

  rxr_byte_packer #(.WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst(rst), .clr(st == ST_DECIDE), .store(store), .flush(flush),
    .lane(byte_cnt[LANE_W-1:0]), .din(rx_data), .word_out(packed_word)
  );

  rxr_next_ptr #(.AW(AW)) u_next (
    .cur(cur_desc), .base(base_q), .link(d_link), .eor(d_eor), .chain(d_chain),
    .next(next_desc)
  );

  rxr_sat_counter #(.W(MISS_W)) u_miss (
    .clk(clk), .rst(rst), .inc(drop_end), .count(miss_count)
  );

  // descriptor capture pipeline: request tag -> data valid tag
  always_ff @(posedge clk) begin
    if (rst) begin
      tag2_v <= 1'b0; tag2_i <= '0;
      d_own <= 1'b0; d_eor <= 1'b0; d_chain <= 1'b0;
      d_size <= '0; d_buf1 <= '0; d_link <= '0;
    end else begin
      tag2_v <= tag1_v;
      tag2_i <= tag1_i;
      if (tag2_v) begin
        case (tag2_i)
          2'd0: d_own <= mem_rdata[OWN_BIT];
          2'd1: begin
            d_size  <= mem_rdata[LEN_W-1:0];
            d_eor   <= mem_rdata[EOR_BIT];
            d_chain <= mem_rdata[CHAIN_BIT];
          end
          2'd2: d_buf1 <= mem_rdata[AW-1:0];
          default: d_link <= mem_rdata[AW-1:0];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      cur_desc <= '0; base_q <= '0; en_q <= 1'b0;
      fidx <= '0; tag1_v <= 1'b0; tag1_i <= '0;
      byte_cnt <= '0; trunc_q <= 1'b0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      en_q    <= cfg_rx_en;
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      tag1_v  <= 1'b0;
      if (cfg_rx_en && !en_q) begin
        base_q   <= cfg_list_base;
        cur_desc <= cfg_list_base;
      end
      case (st)
        ST_IDLE: begin
          fidx <= '0;
          if (cfg_rx_en && en_q && rx_valid) st <= ST_FETCH;
        end
        ST_FETCH: begin
          mem_req  <= 1'b1;
          mem_addr <= cur_desc + AW'(fidx);
          tag1_v   <= 1'b1;
          tag1_i   <= fidx;
          fidx     <= fidx + 1'b1;
          if (fidx == 2'd3) st <= ST_WAITD;
        end
        ST_WAITD: if (tag2_v && tag2_i == 2'd3) st <= ST_DECIDE;
        ST_DECIDE: begin
          byte_cnt <= '0;
          trunc_q  <= 1'b0;
          st <= d_own ? ST_RECV : ST_DROP;
        end
        ST_RECV: if (rx_valid) begin
          if (byte_cnt != '1) byte_cnt <= byte_cnt + 1'b1;
          if (!fits) trunc_q <= 1'b1;
          if (store && flush) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= d_buf1 + AW'(byte_cnt >> LANE_W);
            mem_wdata <= packed_word;
          end
          if (rx_last) st <= ST_WB;
        end
        ST_DROP: if (drop_end) st <= ST_IDLE;
        ST_WB: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= cur_desc;
          mem_wdata <= make_status(stored_len, trunc_q);
          cur_desc  <= next_desc;
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_rx_done <= 1'b0;
      sts_no_desc <= 1'b0;
    end else begin
      if (set_done)        sts_rx_done <= 1'b1;
      else if (sts_clr[0]) sts_rx_done <= 1'b0;
      if (drop_end)        sts_no_desc <= 1'b1;
      else if (sts_clr[1]) sts_no_desc <= 1'b0;
    end
  end

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !cfg_rx_en) |=> (!mem_req && !rx_ready));

  // R3
  no_stream_in_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> !rx_ready);

  // R5
  wb_own_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WB) |=> (mem_req && mem_we && !mem_wdata[OWN_BIT]));

  // R6
  no_write_past_size_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RECV && rx_valid && !fits) |=> !mem_req);

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (sts_clr[0] && !set_done) |=> !sts_rx_done);
endmodule

// File: tb/rx_desc_ring_engine_tb.sv
module rx_desc_ring_engine_tb;
  localparam int AW = 10;
  localparam int MW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_rx_en = 1'b0;
  logic [AW-1:0] cfg_list_base = '0;
  logic rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_ready, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [1:0] sts_clr = '0;
  logic sts_rx_done, sts_no_desc;
  logic [MW-1:0] miss_count;

  always #4 clk = ~clk;

  rx_desc_ring_engine #(.AW(AW), .MISS_W(MW)) u_dut (
    .clk(clk), .rst(rst), .cfg_rx_en(cfg_rx_en), .cfg_list_base(cfg_list_base),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .sts_clr(sts_clr), .sts_rx_done(sts_rx_done),
    .sts_no_desc(sts_no_desc), .miss_count(miss_count)
  );

  logic [31:0] mem [0:(1<<AW)-1] = '{default: 32'h0};
  logic tb_we = 1'b0;
  logic [AW-1:0] tb_addr = '0;
  logic [31:0] tb_wd = '0;
  int rd_count = 0, wr_count = 0;
  logic [AW-1:0] last_waddr = '0;

  always @(posedge clk) begin
    if (tb_we) mem[tb_addr] <= tb_wd;
    else if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_count <= wr_count + 1;
        last_waddr <= mem_addr;
      end else begin
        mem_rdata <= mem[mem_addr];
        rd_count <= rd_count + 1;
      end
    end
  end

  int tests = 0, fails = 0;
  logic [7:0] fb [0:255];
  localparam logic [31:0] SENT = 32'hDEADBEEF;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); tb_we = 1'b1; tb_addr = a; tb_wd = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  function automatic logic [31:0] exp_status(input int n, input int s);
    logic [31:0] w;
    int stored;
    stored = (n > s) ? s : n;
    w = '0;
    w[26:16] = stored[10:0];
    w[1] = (n > s);
    return w;
  endfunction

  function automatic logic [31:0] exp_word(input int widx, input int stored);
    logic [31:0] w;
    w = '0;
    for (int k = 0; k < 4; k++)
      if (widx*4 + k < stored) w[8*k +: 8] = fb[widx*4 + k];
    return w;
  endfunction

  task automatic send_frame(input int n);
    bit acc;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fb[i]; rx_last = (i == n-1);
      forever begin
        acc = rx_ready;
        @(posedge clk);
        if (acc) break;
        @(negedge clk);
      end
    end
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic fill_random(input int n);
    for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
  endtask

  task automatic clear_flags(input logic [1:0] m);
    @(negedge clk); sts_clr = m;
    @(negedge clk); sts_clr = '0;
  endtask

  task automatic run_frame(input logic [AW-1:0] da, input logic [AW-1:0] ba,
                           input logic [31:0] ctl_hi, input logic [AW-1:0] link,
                           input int n, input int s);
    int stored, nw, rd0;
    stored = (n > s) ? s : n;
    nw = (stored + 3) / 4;
    poke(da + 1, ctl_hi | 32'(s));
    poke(da + 2, 32'(ba));
    poke(da + 3, 32'(link));
    poke(da, 32'h8000_0000);
    for (int w = 0; w <= (s + 3) / 4; w++) poke(ba + AW'(w), SENT);
    fill_random(n);
    rd0 = rd_count;
    send_frame(n);
    chk(mem[da] == exp_status(n, s), "R5 status word", mem[da], exp_status(n, s));
    for (int w = 0; w < nw; w++)
      chk(mem[ba + AW'(w)] == exp_word(w, stored), "R4 buffer word",
          mem[ba + AW'(w)], exp_word(w, stored));
    chk(mem[ba + AW'(nw)] == SENT, "R6 past stored data", mem[ba + AW'(nw)], SENT);
    chk(rd_count - rd0 == 4, "R3 descriptor reads", 32'(rd_count - rd0), 32'd4);
    chk(last_waddr == da, "R11 status last write", 32'(last_waddr), 32'(da));
    chk(sts_rx_done == 1'b1, "R9 done set", 32'(sts_rx_done), 32'd1);
    clear_flags(2'b01);
    chk(sts_rx_done == 1'b0, "R9 done cleared", 32'(sts_rx_done), 32'd0);
  endtask

  // ring: D0 plain, D1 chained, D2 end-of-ring with chain bit also set
  localparam logic [AW-1:0] D0 = 10'h100, D1 = 10'h104, D2 = 10'h140;
  localparam logic [AW-1:0] B0 = 10'h200, B1 = 10'h240, B2 = 10'h280;

  task automatic ring_frame(input int idx, input int n, input int s);
    case (idx)
      0: run_frame(D0, B0, 32'h0, '0, n, s);
      1: run_frame(D1, B1, 32'h0100_0000, D2, n, s);
      default: run_frame(D2, B2, 32'h0300_0000, 10'h180, n, s);
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seen_ready, rd0, wr0, idx;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rx_ready == 0, "R1 rx_ready", 32'(rx_ready), 0);
    chk(mem_req == 0, "R1 mem_req", 32'(mem_req), 0);
    chk(sts_rx_done == 0, "R1 done flag", 32'(sts_rx_done), 0);
    chk(sts_no_desc == 0, "R1 no-desc flag", 32'(sts_no_desc), 0);
    chk(miss_count == 0, "R1 miss count", 32'(miss_count), 0);

    // R2 disabled: stream held valid, nothing happens
    rd0 = rd_count; wr0 = wr_count; seen_ready = 0;
    rx_valid = 1'b1; rx_data = 8'h55;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rx_ready) seen_ready++;
    end
    rx_valid = 1'b0;
    chk(seen_ready == 0, "R2 no ready while disabled", 32'(seen_ready), 0);
    chk(rd_count == rd0 && wr_count == wr0, "R2 no memory access",
        32'(rd_count - rd0 + wr_count - wr0), 0);

    // ring with host-owned D0
    poke(D0 + 1, 32'd256); poke(D0 + 2, 32'(B0)); poke(D0 + 3, 0); poke(D0, 0);
    cfg_list_base = D0;
    @(negedge clk); cfg_rx_en = 1'b1;
    repeat (3) @(negedge clk);

    // R7 drop
    rd0 = rd_count; wr0 = wr_count;
    fill_random(5);
    send_frame(5);
    chk(miss_count == 1, "R7 miss count", 32'(miss_count), 1);
    chk(sts_no_desc == 1, "R7 no-desc flag", 32'(sts_no_desc), 1);
    chk(wr_count == wr0, "R7 no writes on drop", 32'(wr_count - wr0), 0);
    chk(mem[D0] == 0, "R7 descriptor untouched", mem[D0], 0);
    chk(rd_count - rd0 == 4, "R3 reads on drop", 32'(rd_count - rd0), 4);
    chk(sts_rx_done == 0, "R9 no done on drop", 32'(sts_rx_done), 0);
    clear_flags(2'b10);
    chk(sts_no_desc == 0, "R9 no-desc cleared", 32'(sts_no_desc), 0);

    // directed: retried D0 (R7), truncation (R6), chain (R8), wrap (R8)
    ring_frame(0, 13, 256);
    ring_frame(1, 11, 7);
    ring_frame(2, 20, 256);
    ring_frame(0, 8, 8);
    ring_frame(1, 1, 256);
    ring_frame(2, 4, 3);
    idx = 0;
    // random mix (R4 R5 R6 R8)
    for (int f = 0; f < 24; f++) begin
      ring_frame(idx, 1 + int'($urandom % 90), 1 + int'($urandom % 80));
      idx = (idx + 1) % 3;
    end

    // R10 base reload while disabled
    @(negedge clk); cfg_rx_en = 1'b0;
    cfg_list_base = 10'h300;
    repeat (2) @(negedge clk);
    cfg_rx_en = 1'b1;
    repeat (2) @(negedge clk);
    run_frame(10'h300, 10'h340, 32'h0200_0000, '0, 9, 64);
    run_frame(10'h300, 10'h340, 32'h0200_0000, '0, 17, 64);

    // R7 saturation: 8 more drops from 1 -> limit 7
    poke(10'h300, 0);
    for (int d = 0; d < 8; d++) begin
      fill_random(2);
      send_frame(2);
    end
    chk(miss_count == 3'd7, "R7 miss saturates", 32'(miss_count), 7);
    chk(mem[10'h300] == 0, "R7 host-owned stays", mem[10'h300], 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule